// File: doc/BRIEF.md
# Delayed Branch Next-PC Sequencer

This block holds the program counter pair of a processor whose control transfers are delayed by one instruction. `pc_o` is the address of the instruction being fetched now, and `npc_o` is the address of the instruction after it. Every clock cycle the block accepts one decoded control-transfer descriptor for the instruction at `pc_o`. The descriptor carries:

- the transfer kind;
- the evaluated condition;
- a "branch always" marker;
- the annul bit;
- a word displacement;
- register operands and a 13-bit immediate for indirect jumps;
- the saved trap PC pair for trap returns.

From these it advances the pair. It also reports two things: whether the delay-slot instruction was skipped, and whether an indirect jump target was misaligned.

The instruction right after a transfer is the delay-slot instruction. It normally runs before the target is reached. The annul bit changes this:

- On a conditional branch, the annul bit drops the slot only when the branch falls through.
- On a branch-always, the annul bit always drops the slot.

When the slot is dropped, the pair moves straight past it, so the slot is never fetched and can have no effect. Instruction decode, condition evaluation, trap entry and the register file sit outside the block and feed its input ports.

Top module: `ctl_xfer_seq`

## Requirements
- R1: While `rst_n` is low, `pc_o` is RESET_PC, `npc_o` is RESET_PC+4, and `squash_o` and `misalign_o` are 0.
- R2: With kind 0 (sequential), the next `pc_o` is the old `npc_o` and the next `npc_o` is the old `npc_o`+4.
- R3: For branch kinds 1, 2 and 3, the target is `pc_o` plus the sign-extended low 22, 19 or 16 bits of `disp_i` shifted left by 2. Bits of `disp_i` above that width are ignored. A taken branch that is not branch-always sets next `pc_o` = old `npc_o` and next `npc_o` = target, whatever the annul bit, with `squash_o` = 0.
- R4: A branch with `always_i`=0, `cond_i`=0 and `annul_i`=0 acts as sequential, with `squash_o` = 0.
- R5: A branch with `always_i`=0, `cond_i`=0 and `annul_i`=1 skips its slot: next `pc_o` = old `npc_o`+4, next `npc_o` = old `npc_o`+8, and `squash_o` = 1.
- R6: A branch with `always_i`=1 is taken regardless of `cond_i`. With `annul_i`=1 it sets next `pc_o` = target, next `npc_o` = target+4 and `squash_o` = 1. With `annul_i`=0 it behaves as a taken branch under R3.
- R7: Kind 4 (call) uses all 30 bits of `disp_i` as a signed word displacement from `pc_o`. It is always taken, ignores `annul_i` and `cond_i`, and never sets `squash_o`.
- R8: Kind 5 (indirect jump) forms its target as `rs1_i`+`rs2_i` when `use_imm_i`=0, or as `rs1_i` plus sign-extended `imm_i` when `use_imm_i`=1. An aligned target gives next `pc_o` = old `npc_o` and next `npc_o` = target.
- R9: A kind 5 target whose low two bits are not 00 leaves `pc_o` and `npc_o` unchanged and sets `misalign_o` to 1 for that step only.
- R10: Kind 6 (retry) loads `pc_o` from `tpc_i` and `npc_o` from `tnpc_i`.
- R11: Kind 7 (done) loads `pc_o` from `tnpc_i` and `npc_o` from `tnpc_i`+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kind_i | input | 3 | Transfer kind, 0 to 7 as in R2 to R11 |
| cond_i | input | 1 | Branch condition evaluated true |
| always_i | input | 1 | Branch is unconditional (branch-always) |
| annul_i | input | 1 | Annul bit of the transfer |
| disp_i | input | 30 | Word displacement field |
| rs1_i | input | ADDR_W | First register operand for indirect jump |
| rs2_i | input | ADDR_W | Second register operand for indirect jump |
| imm_i | input | 13 | Signed immediate for indirect jump |
| use_imm_i | input | 1 | Select immediate instead of rs2 |
| tpc_i | input | ADDR_W | Saved trap PC |
| tnpc_i | input | ADDR_W | Saved trap next PC |
| pc_o | output | ADDR_W | Current fetch address |
| npc_o | output | ADDR_W | Next fetch address |
| squash_o | output | 1 | Last step skipped a delay slot |
| misalign_o | output | 1 | Last step rejected a misaligned jump target |

## Verification
The bench targets several corner cases, each paired with the fault it would expose:

- **Annul bit on a taken conditional branch versus a branch-always.** A design that mixed these up would either skip a slot that must run or run a slot that must vanish.
- **Displacements with their sign bit set and with stray upper bits above the field width.** These expose a wrong extension width, which would send the branch to a far or reversed target.
- **Misaligned indirect targets.** A faulty design would advance the pair or leave the flag raised for longer than one step.
- **Retry and done back to back.** A design that swapped the saved PC pair would resume at the wrong instruction.

// File: rtl/ctl_xfer_pkg.sv
package ctl_xfer_pkg;

   typedef enum logic [2:0] {
      CX_SEQ     = 3'd0,
      CX_BR_WIDE = 3'd1,
      CX_BR_MID  = 3'd2,
      CX_BR_REG  = 3'd3,
      CX_CALL    = 3'd4,
      CX_JMPL    = 3'd5,
      CX_RETRY   = 3'd6,
      CX_DONE    = 3'd7
   } cx_kind_e;

   localparam int CX_NREL   = 4;
   localparam int CX_DISP_W = 30;
   localparam int CX_IMM_W  = 13;
   localparam int CX_WSHIFT = 2;

   // Word displacement width used by each PC-relative kind, in kind order.
   function automatic int rel_width(int idx);
      case (idx)
         0:       return 22;
         1:       return 19;
         2:       return 16;
         default: return CX_DISP_W;
      endcase
   endfunction

endpackage

// File: rtl/ctl_xfer_sext.sv
module ctl_xfer_sext #(
   parameter int IN_W  = 22,
   parameter int OUT_W = 64,
   parameter int SHIFT = 2
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] dout
);
   if (IN_W + SHIFT > OUT_W) begin : g_bad_w
      $error("ctl_xfer_sext: IN_W+SHIFT exceeds OUT_W");
   end

   logic signed [OUT_W-1:0] ext;

   assign ext  = OUT_W'($signed(din));
   assign dout = ext <<< SHIFT;

endmodule

// File: rtl/ctl_xfer_tgt.sv
module ctl_xfer_tgt
   import ctl_xfer_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic [ADDR_W-1:0]    pc_i,
   input  cx_kind_e             kind_i,
   input  logic [CX_DISP_W-1:0] disp_i,
   input  logic [ADDR_W-1:0]    rs1_i,
   input  logic [ADDR_W-1:0]    rs2_i,
   input  logic [CX_IMM_W-1:0]  imm_i,
   input  logic                 use_imm_i,
   output logic [ADDR_W-1:0]    rel_tgt_o,
   output logic [ADDR_W-1:0]    ind_tgt_o,
   output logic                 misal_o
);
   localparam int IDX_W = $clog2(CX_NREL);

   logic [ADDR_W-1:0] ofs [CX_NREL];
   logic [IDX_W-1:0]  rel_idx;
   logic [ADDR_W-1:0] imm_ext;

   for (genvar g = 0; g < CX_NREL; g++) begin : g_rel
      localparam int W = rel_width(g);
      ctl_xfer_sext #(
         .IN_W (W),
         .OUT_W(ADDR_W),
         .SHIFT(CX_WSHIFT)
      ) u_ext (
         .din (disp_i[W-1:0]),
         .dout(ofs[g])
      );
   end

   always_comb begin
      case (kind_i)
         CX_BR_WIDE: rel_idx = IDX_W'(0);
         CX_BR_MID:  rel_idx = IDX_W'(1);
         CX_BR_REG:  rel_idx = IDX_W'(2);
         default:    rel_idx = IDX_W'(3);
      endcase
   end

   assign rel_tgt_o = pc_i + ofs[rel_idx];

   ctl_xfer_sext #(
      .IN_W (CX_IMM_W),
      .OUT_W(ADDR_W),
      .SHIFT(0)
   ) u_imm (
      .din (imm_i),
      .dout(imm_ext)
   );

   assign ind_tgt_o = rs1_i + (use_imm_i ? imm_ext : rs2_i);
   assign misal_o   = |ind_tgt_o[CX_WSHIFT-1:0];

endmodule

// File: rtl/ctl_xfer_nxt.sv
module ctl_xfer_nxt
   import ctl_xfer_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [ADDR_W-1:0] npc_i,
   input  cx_kind_e          kind_i,
   input  logic              cond_i,
   input  logic              always_i,
   input  logic              annul_i,
   input  logic [ADDR_W-1:0] rel_tgt_i,
   input  logic [ADDR_W-1:0] ind_tgt_i,
   input  logic              misal_i,
   input  logic [ADDR_W-1:0] tpc_i,
   input  logic [ADDR_W-1:0] tnpc_i,
   output logic [ADDR_W-1:0] nxt_pc_o,
   output logic [ADDR_W-1:0] nxt_npc_o,
   output logic              nxt_sq_o,
   output logic              nxt_mis_o
);
   localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(8);

   logic [ADDR_W-1:0] npc_p4, npc_p8, tgt_p4, tnpc_p4;

   assign npc_p4  = npc_i + STEP;
   assign npc_p8  = npc_i + STEP2;
   assign tgt_p4  = rel_tgt_i + STEP;
   assign tnpc_p4 = tnpc_i + STEP;

   always_comb begin
      nxt_pc_o  = npc_i;
      nxt_npc_o = npc_p4;
      nxt_sq_o  = 1'b0;
      nxt_mis_o = 1'b0;
      case (kind_i)
         CX_BR_WIDE, CX_BR_MID, CX_BR_REG: begin
            if (always_i) begin
               if (annul_i) begin
                  nxt_pc_o  = rel_tgt_i;
                  nxt_npc_o = tgt_p4;
                  nxt_sq_o  = 1'b1;
               end else begin
                  nxt_npc_o = rel_tgt_i;
               end
            end else if (cond_i) begin
               nxt_npc_o = rel_tgt_i;
            end else if (annul_i) begin
               nxt_pc_o  = npc_p4;
               nxt_npc_o = npc_p8;
               nxt_sq_o  = 1'b1;
            end
         end
         CX_CALL: nxt_npc_o = rel_tgt_i;
         CX_JMPL: begin
            if (misal_i) begin
               nxt_pc_o  = pc_i;
               nxt_npc_o = npc_i;
               nxt_mis_o = 1'b1;
            end else begin
               nxt_npc_o = ind_tgt_i;
            end
         end
         CX_RETRY: begin
            nxt_pc_o  = tpc_i;
            nxt_npc_o = tnpc_i;
         end
         CX_DONE: begin
            nxt_pc_o  = tnpc_i;
            nxt_npc_o = tnpc_p4;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/ctl_xfer_seq.sv
module ctl_xfer_seq
   import ctl_xfer_pkg::*;
#(
   parameter int                ADDR_W   = 64,
   parameter logic [ADDR_W-1:0] RESET_PC = ADDR_W'(0)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        kind_i,
   input  logic              cond_i,
   input  logic              always_i,
   input  logic              annul_i,
   input  logic [29:0]       disp_i,
   input  logic [ADDR_W-1:0] rs1_i,
   input  logic [ADDR_W-1:0] rs2_i,
   input  logic [12:0]       imm_i,
   input  logic              use_imm_i,
   input  logic [ADDR_W-1:0] tpc_i,
   input  logic [ADDR_W-1:0] tnpc_i,
   output logic [ADDR_W-1:0] pc_o,
   output logic [ADDR_W-1:0] npc_o,
   output logic              squash_o,
   output logic              misalign_o
);
   if (ADDR_W < CX_DISP_W + CX_WSHIFT) begin : g_bad_addr
      $error("ctl_xfer_seq: ADDR_W too narrow for call displacement");
   end
   if (RESET_PC[CX_WSHIFT-1:0] != '0) begin : g_bad_rst
      $error("ctl_xfer_seq: RESET_PC must be word aligned");
   end

   cx_kind_e          kind;
   logic [ADDR_W-1:0] rel_tgt, ind_tgt, nxt_pc, nxt_npc;
   logic              misal, nxt_sq, nxt_mis;

   assign kind = cx_kind_e'(kind_i);

   ctl_xfer_tgt #(.ADDR_W(ADDR_W)) u_tgt (
      .pc_i     (pc_o),
      .kind_i   (kind),
      .disp_i   (disp_i),
      .rs1_i    (rs1_i),
      .rs2_i    (rs2_i),
      .imm_i    (imm_i),
      .use_imm_i(use_imm_i),
      .rel_tgt_o(rel_tgt),
      .ind_tgt_o(ind_tgt),
      .misal_o  (misal)
   );

   ctl_xfer_nxt #(.ADDR_W(ADDR_W)) u_nxt (
      .pc_i     (pc_o),
      .npc_i    (npc_o),
      .kind_i   (kind),
      .cond_i   (cond_i),
      .always_i (always_i),
      .annul_i  (annul_i),
      .rel_tgt_i(rel_tgt),
      .ind_tgt_i(ind_tgt),
      .misal_i  (misal),
      .tpc_i    (tpc_i),
      .tnpc_i   (tnpc_i),
      .nxt_pc_o (nxt_pc),
      .nxt_npc_o(nxt_npc),
      .nxt_sq_o (nxt_sq),
      .nxt_mis_o(nxt_mis)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_o       <= RESET_PC;
         npc_o      <= RESET_PC + ADDR_W'(4);
         squash_o   <= 1'b0;
         misalign_o <= 1'b0;
      end else begin
         pc_o       <= nxt_pc;
         npc_o      <= nxt_npc;
         squash_o   <= nxt_sq;
         misalign_o <= nxt_mis;
      end
   end

endmodule

// File: rtl/ctl_xfer_chk.sv
module ctl_xfer_chk #(
   parameter int ADDR_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        kind_i,
   input logic              cond_i,
   input logic              always_i,
   input logic              annul_i,
   input logic [ADDR_W-1:0] tpc_i,
   input logic [ADDR_W-1:0] tnpc_i,
   input logic [ADDR_W-1:0] pc_o,
   input logic [ADDR_W-1:0] npc_o,
   input logic              squash_o,
   input logic              misalign_o
);
   logic is_br;
   assign is_br = (kind_i == 3'd1) || (kind_i == 3'd2) || (kind_i == 3'd3);

   a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == 3'd0) |=> (pc_o == $past(npc_o)) && (npc_o == $past(npc_o) + ADDR_W'(4)));

   a_r3_taken_runs_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (is_br && !always_i && cond_i) |=> !squash_o && (pc_o == $past(npc_o)));

   a_r5_skip_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (is_br && !always_i && !cond_i && annul_i) |=>
         squash_o && (pc_o == $past(npc_o) + ADDR_W'(4)) && (npc_o == $past(npc_o) + ADDR_W'(8)));

   a_r6_always_squash: assert property (@(posedge clk) disable iff (!rst_n)
      (is_br && always_i && annul_i) |=> squash_o && (npc_o == pc_o + ADDR_W'(4)));

   a_r7_call_no_squash: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == 3'd4) |=> !squash_o && (pc_o == $past(npc_o)));

   a_r9_misalign_hold: assert property (@(posedge clk) disable iff (!rst_n)
      misalign_o |-> (pc_o == $past(pc_o)) && (npc_o == $past(npc_o)) && !squash_o);

   a_r10_retry_load: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == 3'd6) |=> (pc_o == $past(tpc_i)) && (npc_o == $past(tnpc_i)));

   a_r11_done_load: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == 3'd7) |=> (pc_o == $past(tnpc_i)) && (npc_o == $past(tnpc_i) + ADDR_W'(4)));

endmodule

bind ctl_xfer_seq ctl_xfer_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/ctl_xfer_seq_tb.sv
module ctl_xfer_seq_tb_top;
   localparam int AW = 64;
   localparam logic [AW-1:0] RPC = 64'h0000_0000_0040_1000;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [2:0]    kind_i;
   logic          cond_i, always_i, annul_i, use_imm_i;
   logic [29:0]   disp_i;
   logic [AW-1:0] rs1_i, rs2_i, tpc_i, tnpc_i;
   logic [12:0]   imm_i;
   logic [AW-1:0] pc_o, npc_o;
   logic          squash_o, misalign_o;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [AW-1:0] m_pc, m_npc;
   logic          m_sq, m_mis;

   always #4 clk = ~clk;

   ctl_xfer_seq #(.ADDR_W(AW), .RESET_PC(RPC)) dut_i (
      .clk(clk), .rst_n(rst_n), .kind_i(kind_i), .cond_i(cond_i),
      .always_i(always_i), .annul_i(annul_i), .disp_i(disp_i),
      .rs1_i(rs1_i), .rs2_i(rs2_i), .imm_i(imm_i), .use_imm_i(use_imm_i),
      .tpc_i(tpc_i), .tnpc_i(tnpc_i), .pc_o(pc_o), .npc_o(npc_o),
      .squash_o(squash_o), .misalign_o(misalign_o)
   );

   function automatic logic [AW-1:0] sx(logic [29:0] d, int w);
      logic [AW-1:0] r;
      for (int i = 0; i < AW; i++) r[i] = (i < w) ? d[i] : d[w-1];
      return r;
   endfunction

   function automatic logic [AW-1:0] rnd64();
      return {$urandom(), $urandom()};
   endfunction

   task automatic check(string req);
      n_run++;
      if (pc_o !== m_pc || npc_o !== m_npc || squash_o !== m_sq || misalign_o !== m_mis) begin
         n_fail++;
         $display("FAIL %s: actual pc=%h npc=%h sq=%b mis=%b expected pc=%h npc=%h sq=%b mis=%b",
                  req, pc_o, npc_o, squash_o, misalign_o, m_pc, m_npc, m_sq, m_mis);
      end
   endtask

   task automatic set_in(logic [2:0] k, logic c, logic a, logic an, logic [29:0] d,
                         logic [AW-1:0] r1, logic [AW-1:0] r2, logic [12:0] im,
                         logic ui, logic [AW-1:0] tp, logic [AW-1:0] tn);
      kind_i = k; cond_i = c; always_i = a; annul_i = an; disp_i = d;
      rs1_i = r1; rs2_i = r2; imm_i = im; use_imm_i = ui; tpc_i = tp; tnpc_i = tn;
   endtask

   // Compute the expected pair from the requirements, advance one clock, compare.
   task automatic step();
      logic [AW-1:0] tgt, e_pc, e_npc;
      logic          e_sq, e_mis;
      string         req;
      e_pc = m_npc; e_npc = m_npc + 64'd4; e_sq = 1'b0; e_mis = 1'b0; req = "R2";
      case (kind_i)
         3'd1, 3'd2, 3'd3: begin
            tgt = m_pc + (sx(disp_i, (kind_i == 3'd1) ? 22 : (kind_i == 3'd2) ? 19 : 16) << 2);
            if (always_i && annul_i) begin
               e_pc = tgt; e_npc = tgt + 64'd4; e_sq = 1'b1; req = "R6";
            end else if (always_i || cond_i) begin
               e_npc = tgt; req = always_i ? "R6" : "R3";
            end else if (annul_i) begin
               e_pc = m_npc + 64'd4; e_npc = m_npc + 64'd8; e_sq = 1'b1; req = "R5";
            end else begin
               req = "R4";
            end
         end
         3'd4: begin
            e_npc = m_pc + (sx(disp_i, 30) << 2); req = "R7";
         end
         3'd5: begin
            tgt = rs1_i + (use_imm_i ? sx({17'd0, imm_i}, 13) : rs2_i);
            if (tgt[1:0] != 2'b00) begin
               e_pc = m_pc; e_npc = m_npc; e_mis = 1'b1; req = "R9";
            end else begin
               e_npc = tgt; req = "R8";
            end
         end
         3'd6: begin e_pc = tpc_i; e_npc = tnpc_i; req = "R10"; end
         3'd7: begin e_pc = tnpc_i; e_npc = tnpc_i + 64'd4; req = "R11"; end
         default: ;
      endcase
      @(posedge clk);
      #1;
      m_pc = e_pc; m_npc = e_npc; m_sq = e_sq; m_mis = e_mis;
      check(req);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual no completion expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] r1, r2;
      void'($urandom(32'd20240611));
      rst_n = 1'b0;
      set_in(3'd0, 0, 0, 0, '0, '0, '0, '0, 0, '0, '0);
      repeat (3) @(posedge clk);
      #1;
      m_pc = RPC; m_npc = RPC + 64'd4; m_sq = 1'b0; m_mis = 1'b0;
      check("R1");
      rst_n = 1'b1;

      // R2 sequential flow
      step(); step();
      // R3 wide branch, negative extreme displacement, annul set, taken
      set_in(3'd1, 1, 0, 1, 30'h0020_0000, '0, '0, '0, 0, '0, '0); step();
      // R3 register-branch with garbage above bit 15
      set_in(3'd3, 1, 0, 0, 30'h3FFF_0010, '0, '0, '0, 0, '0, '0); step();
      // R3 mid branch, positive displacement with bits above 18 set
      set_in(3'd2, 1, 0, 0, 30'h3FF8_0123, '0, '0, '0, 0, '0, '0); step();
      // R4 not taken, no annul
      set_in(3'd1, 0, 0, 0, 30'h0000_0100, '0, '0, '0, 0, '0, '0); step();
      // R5 not taken with annul skips slot
      set_in(3'd2, 0, 0, 1, 30'h0000_0100, '0, '0, '0, 0, '0, '0); step();
      // R6 branch-always with annul, cond low
      set_in(3'd1, 0, 1, 1, 30'h0000_0040, '0, '0, '0, 0, '0, '0); step();
      // R6 branch-always without annul
      set_in(3'd3, 0, 1, 0, 30'h0000_FFFF, '0, '0, '0, 0, '0, '0); step();
      // R7 call with annul and cond set, negative full-width displacement
      set_in(3'd4, 1, 1, 1, 30'h2000_0000, '0, '0, '0, 0, '0, '0); step();
      // R8 register + negative immediate
      set_in(3'd5, 0, 0, 0, '0, 64'h0000_0000_0080_0010, '0, 13'h1FF0, 1, '0, '0); step();
      // R8 register + register
      set_in(3'd5, 0, 0, 0, '0, 64'h0000_0000_0001_0000, 64'h0000_0000_0000_0204, '0, 0, '0, '0); step();
      // R9 misaligned, then sequential clears the flag
      set_in(3'd5, 0, 0, 0, '0, 64'h0000_0000_0000_1000, '0, 13'h0002, 1, '0, '0); step();
      set_in(3'd0, 0, 0, 0, '0, '0, '0, '0, 0, '0, '0); step();
      // R10 retry then R11 done
      set_in(3'd6, 0, 0, 0, '0, '0, '0, '0, 0, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_9000); step();
      set_in(3'd7, 0, 0, 0, '0, '0, '0, '0, 0, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_A000); step();

      for (int i = 0; i < 3000; i++) begin
         r1 = rnd64();
         r2 = rnd64();
         if ($urandom() % 4 != 0) begin r1[1:0] = 2'b00; r2[1:0] = 2'b00; end
         set_in(3'($urandom() % 8), 1'($urandom()), 1'($urandom() % 4 == 0), 1'($urandom()),
                30'($urandom()), r1, r2, 13'($urandom()), 1'($urandom()),
                {rnd64() >> 2, 2'b00} , {rnd64() >> 2, 2'b00});
         step();
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule